// File: doc/BRIEF.md
# Branch Condition and Target Resolver

This block sits beside the fetch stage of a 32-bit processor. It takes the address of the current control-transfer instruction, the branch kind chosen by the decoder, two register operands, a 16-bit word offset, a 26-bit jump index and the condition flag reported by a coprocessor. In the same cycle it decides whether control leaves the sequential path and where it goes.

It also reports whether a return address must be written and what that address is. Every linking form writes register 31. The caller uses the link enable to steer the write. All logic is combinational, with no state.

Top module: `br_resolve`

## Requirements
- R1: With kind code 0 (none), `taken_o` is 0, `next_pc_o` is `pc_i`+4 and `link_en_o` is 0. Whenever `taken_o` is 0, `next_pc_o` is `pc_i`+4 and `link_en_o` is 0.
- R2: Code 1 (equal) is taken when `rs_i` equals `rt_i`. Code 2 (not-equal) is taken when they differ.
- R3: The zero tests read `rs_i` as signed. Code 3 (>=0), code 4 (>0), code 5 (<=0) and code 6 (<0) are each taken when their test holds.
- R4: For codes 1 to 10, the taken target is `pc_i`+4 plus the sign-extended `off_i` shifted left by 2, modulo 2^32.
- R5: Code 7 (>=0 and link) and code 8 (<0 and link) test like codes 3 and 6. They raise `link_en_o` only when taken.
- R6: Code 9 is taken when `cpflag_i` is 1. Code 10 is taken when `cpflag_i` is 0.
- R7: Code 11 (jump) and code 12 (jump and link) are always taken. Their target is bits 31:28 of `pc_i`+4 joined with `idx_i` shifted left by 2. Code 12 raises `link_en_o`.
- R8: Code 13 (jump register) and code 14 (jump register and link) are always taken, with target `rs_i`. Code 14 raises `link_en_o`.
- R9: `link_val_o` always equals `pc_i`+4, modulo 2^32.
- R10: Code 15 behaves like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the control instruction |
| kind_i | input | 4 | Branch kind code |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand |
| off_i | input | 16 | Signed word offset |
| idx_i | input | 26 | Jump word index |
| cpflag_i | input | 1 | Coprocessor condition flag |
| taken_o | output | 1 | Control leaves the sequential path |
| next_pc_o | output | 32 | Address of the next instruction |
| link_en_o | output | 1 | Write the return address to register 31 |
| link_val_o | output | 32 | Return address |

## Verification
Assertions inside the module are evaluated on every input change. They cover the fall-through rule (R1), the equal/not-equal and sign-test decisions (R2, R3), link only when taken (R5), the coprocessor flag (R6), register jumps (R8) and the link value (R9). The exact computed targets cannot be shown that way: offset sign extension, address wrap, the region bits of a direct jump (R4, R7) and the handling of the spare code (R10). The bench scenarios show these, using hand-computed addresses.

// File: rtl/br_resolve.sv
module br_resolve #(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  parameter int IDXW = 26
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [3:0]      kind_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic            cpflag_i,
  output logic            taken_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            link_en_o,
  output logic [XLEN-1:0] link_val_o
);
  localparam logic [3:0] K_NONE = 4'd0,  K_EQ   = 4'd1,  K_NE   = 4'd2,
                         K_GEZ  = 4'd3,  K_GTZ  = 4'd4,  K_LEZ  = 4'd5,
                         K_LTZ  = 4'd6,  K_GEZL = 4'd7,  K_LTZL = 4'd8,
                         K_CPT  = 4'd9,  K_CPF  = 4'd10, K_J    = 4'd11,
                         K_JL   = 4'd12, K_JR   = 4'd13, K_JRL  = 4'd14;
  localparam int HI = XLEN - IDXW - 2;

  logic [XLEN-1:0] seq_pc, br_tgt, j_tgt, tgt;
  logic neg, zero, cond, lnk;

  assign seq_pc = pc_i + XLEN'(4);
  assign br_tgt = seq_pc + {{(XLEN-OFFW-2){off_i[OFFW-1]}}, off_i, 2'b00};
  assign j_tgt  = {seq_pc[XLEN-1 -: HI], idx_i, 2'b00};
  assign neg    = rs_i[XLEN-1];
  assign zero   = (rs_i == '0);

  always_comb begin
    cond = 1'b0;
    lnk  = 1'b0;
    tgt  = br_tgt;
    case (kind_i)
      K_EQ:   cond = (rs_i == rt_i);
      K_NE:   cond = (rs_i != rt_i);
      K_GEZ:  cond = !neg;
      K_GTZ:  cond = !neg && !zero;
      K_LEZ:  cond = neg || zero;
      K_LTZ:  cond = neg;
      K_GEZL: begin cond = !neg; lnk = 1'b1; end
      K_LTZL: begin cond = neg;  lnk = 1'b1; end
      K_CPT:  cond = cpflag_i;
      K_CPF:  cond = !cpflag_i;
      K_J:    begin cond = 1'b1; tgt = j_tgt; end
      K_JL:   begin cond = 1'b1; tgt = j_tgt; lnk = 1'b1; end
      K_JR:   begin cond = 1'b1; tgt = rs_i; end
      K_JRL:  begin cond = 1'b1; tgt = rs_i; lnk = 1'b1; end
      default: cond = 1'b0;
    endcase
  end

  assign taken_o    = cond;
  assign next_pc_o  = cond ? tgt : seq_pc;
  assign link_en_o  = cond && lnk;
  assign link_val_o = seq_pc;

  always_comb begin
    if (!taken_o)
      p_fallthru_r1: assert (next_pc_o == pc_i + XLEN'(4) && !link_en_o)
        else $error("fall-through broken");
    if (kind_i == K_EQ || kind_i == K_NE)
      p_cmp_r2: assert (taken_o == ((rs_i == rt_i) == (kind_i == K_EQ)))
        else $error("eq/ne decision broken");
    if (kind_i == K_LTZ || kind_i == K_LTZL)
      p_sign_r3: assert (taken_o == rs_i[XLEN-1])
        else $error("sign test broken");
    if (link_en_o)
      p_link_taken_r5: assert (taken_o) else $error("link without taken");
    if (kind_i == K_CPT || kind_i == K_CPF)
      p_cop_r6: assert (taken_o == (cpflag_i == (kind_i == K_CPT)))
        else $error("coprocessor flag test broken");
    if (kind_i == K_JR || kind_i == K_JRL)
      p_jreg_r8: assert (taken_o && next_pc_o == rs_i && link_en_o == (kind_i == K_JRL))
        else $error("register jump broken");
    p_linkval_r9: assert (link_val_o - pc_i == XLEN'(4))
      else $error("link value broken");
  end
endmodule

// File: tb/br_resolve_tb_top.sv
module br_resolve_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] pc, rs, rt, npc, lval;
  logic [3:0]  kind;
  logic [15:0] off;
  logic [25:0] idx;
  logic        flag, taken, len;

  br_resolve dut_i (
    .pc_i(pc), .kind_i(kind), .rs_i(rs), .rt_i(rt), .off_i(off),
    .idx_i(idx), .cpflag_i(flag), .taken_o(taken), .next_pc_o(npc),
    .link_en_o(len), .link_val_o(lval)
  );

  typedef struct {
    string       req;
    logic        t;
    logic [31:0] np;
    logic        le;
    logic [31:0] lv;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic drive(input string req, input logic [31:0] p, input logic [3:0] k,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] o,
                       input logic [25:0] ix, input logic f, input logic et,
                       input logic [31:0] enp, input logic ele, input logic [31:0] elv);
    exp_t e;
    @(posedge clk);
    pc = p; kind = k; rs = a; rt = b; off = o; idx = ix; flag = f;
    e.req = req; e.t = et; e.np = enp; e.le = ele; e.lv = elv;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (taken !== e.t || npc !== e.np || len !== e.le || lval !== e.lv) begin
        errors++;
        $display("FAIL %s: got taken=%0b npc=%h link=%0b lval=%h exp taken=%0b npc=%h link=%0b lval=%h",
                 e.req, taken, npc, len, lval, e.t, e.np, e.le, e.lv);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang exp finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    pc = 0; kind = 0; rs = 0; rt = 0; off = 0; idx = 0; flag = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (taken !== 1'b0 || npc !== 32'h4 || len !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got taken=%0b npc=%h exp taken=0 npc=00000004", taken, npc);
    end
    // R1 none
    drive("R1 none", 32'h1000, 4'd0, 5, 5, 16'h10, 0, 1, 0, 32'h1004, 0, 32'h1004);
    // R2 equal / not-equal, R4 offsets
    drive("R2 eq hit", 32'h1000, 4'd1, 5, 5, 16'h0010, 0, 0, 1, 32'h1044, 0, 32'h1004);
    drive("R2 eq miss", 32'h1000, 4'd1, 5, 6, 16'h0010, 0, 0, 0, 32'h1004, 0, 32'h1004);
    drive("R2 R4 ne back", 32'h1000, 4'd2, 5, 6, 16'hFFFF, 0, 0, 1, 32'h1000, 0, 32'h1004);
    drive("R2 ne miss", 32'h1000, 4'd2, 7, 7, 16'hFFFF, 0, 0, 0, 32'h1004, 0, 32'h1004);
    // R3 zero tests
    drive("R3 gez zero", 32'h1000, 4'd3, 0, 0, 16'h2, 0, 0, 1, 32'h100C, 0, 32'h1004);
    drive("R3 gez neg", 32'h1000, 4'd3, 32'h80000000, 0, 16'h2, 0, 0, 0, 32'h1004, 0, 32'h1004);
    drive("R3 gtz zero", 32'h1000, 4'd4, 0, 0, 16'h2, 0, 0, 0, 32'h1004, 0, 32'h1004);
    drive("R3 gtz one", 32'h1000, 4'd4, 1, 0, 16'h2, 0, 0, 1, 32'h100C, 0, 32'h1004);
    drive("R3 lez zero", 32'h1000, 4'd5, 0, 0, 16'h2, 0, 0, 1, 32'h100C, 0, 32'h1004);
    drive("R3 lez neg", 32'h1000, 4'd5, 32'hFFFFFFFF, 0, 16'h2, 0, 0, 1, 32'h100C, 0, 32'h1004);
    drive("R3 lez pos", 32'h1000, 4'd5, 7, 0, 16'h2, 0, 0, 0, 32'h1004, 0, 32'h1004);
    drive("R3 ltz neg", 32'h1000, 4'd6, 32'hFFFFFFFF, 0, 16'h2, 0, 0, 1, 32'h100C, 0, 32'h1004);
    drive("R3 ltz zero", 32'h1000, 4'd6, 0, 0, 16'h2, 0, 0, 0, 32'h1004, 0, 32'h1004);
    // R5 linking branches
    drive("R5 gezl taken", 32'h1000, 4'd7, 3, 0, 16'h1, 0, 0, 1, 32'h1008, 1, 32'h1004);
    drive("R5 gezl not", 32'h1000, 4'd7, 32'hFFFFFFFF, 0, 16'h1, 0, 0, 0, 32'h1004, 0, 32'h1004);
    drive("R5 R4 ltzl far", 32'h1000, 4'd8, 32'hFFFFFFFB, 0, 16'h8000, 0, 0, 1, 32'hFFFE1004, 1, 32'h1004);
    drive("R5 ltzl not", 32'h1000, 4'd8, 0, 0, 16'h8000, 0, 0, 0, 32'h1004, 0, 32'h1004);
    // R6 coprocessor flag
    drive("R6 cpt hit", 32'h1000, 4'd9, 0, 0, 16'h4, 0, 1, 1, 32'h1014, 0, 32'h1004);
    drive("R6 cpt miss", 32'h1000, 4'd9, 0, 0, 16'h4, 0, 0, 0, 32'h1004, 0, 32'h1004);
    drive("R6 cpf hit", 32'h1000, 4'd10, 0, 0, 16'h4, 0, 0, 1, 32'h1014, 0, 32'h1004);
    drive("R6 cpf miss", 32'h1000, 4'd10, 0, 0, 16'h4, 0, 1, 0, 32'h1004, 0, 32'h1004);
    // R7 direct jumps
    drive("R7 j region", 32'hA0000000, 4'd11, 0, 0, 0, 26'h0123456, 0, 1, 32'hA048D158, 0, 32'hA0000004);
    drive("R7 j region carry", 32'hAFFFFFFC, 4'd11, 0, 0, 0, 26'h1, 0, 1, 32'hB0000004, 0, 32'hB0000000);
    drive("R7 j max idx", 32'h1000, 4'd11, 0, 0, 0, 26'h3FFFFFF, 0, 1, 32'h0FFFFFFC, 0, 32'h1004);
    drive("R7 jal", 32'h1000, 4'd12, 0, 0, 0, 26'h10, 0, 1, 32'h40, 1, 32'h1004);
    // R8 register jumps
    drive("R8 jr", 32'h1000, 4'd13, 32'h2000, 0, 0, 0, 0, 1, 32'h2000, 0, 32'h1004);
    drive("R8 jrl", 32'h1000, 4'd14, 32'h2468, 0, 0, 0, 0, 1, 32'h2468, 1, 32'h1004);
    // R9 link value wraps, R4 branch wrap
    drive("R9 R4 wrap", 32'hFFFFFFFC, 4'd1, 9, 9, 16'h1, 0, 0, 1, 32'h4, 0, 32'h0);
    // R10 spare code
    drive("R10 spare", 32'h1000, 4'd15, 5, 5, 16'h10, 26'h10, 1, 0, 32'h1004, 0, 32'h1004);
    @(posedge clk);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule